// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Self-Clearing Clear Register

This block gathers a wide vector of interrupt source lines (64 by default) into a single registered interrupt request. Software manages it through a small register port with three register kinds, each split into 32-bit words: a mask, a sticky status and a clear register. An enabled source that is active sets its status bit, and the bit stays set after the source goes away. The interrupt request is the OR of all status bits.

To drop a status bit, software writes a 1 to the matching bit of the clear register. That register keeps the written value for exactly one cycle and then returns to zero by itself, so no second write is needed. A short hold-off after each clear means a source that is still active comes back in a fixed, predictable number of cycles. Masking is applied before capture, so a masked source never reaches status. Writes to status are ignored.

Top module: `irq_aggregator`

## Requirements
- R1: Reset sets every mask bit to 1 and every status and clear bit to 0, and it drives irqOut low.
- R2: A source whose mask bit is 1 never sets its status bit, whatever its level.
- R3: A source whose mask bit is 0 and which is high at a rising edge sets its status bit at that edge, when no clear or hold-off applies to that bit. The bit then stays at 1 after the source goes low, until it is cleared.
- R4: irqOut is registered. It equals the OR of all status bits as they stood one cycle earlier. It therefore falls on the edge after the last set status bit clears.
- R5: A write to a clear word loads that word at the write edge, and each bit written as 1 zeroes its status bit at the next edge. Status bits written as 0 keep their value.
- R6: The clear register returns to zero one cycle after a write with no further write, and reading a clear word always returns 0.
- R7: After a clear pulse, the same bits are held off from capture for one more cycle. A source that stays high re-sets its status bit on the third edge after the clear write. It does not re-set it on the first or second edge.
- R8: When capture and a clear hit the same status bit at the same edge, the clear wins and the bit ends at 0.
- R9: Writes to a status word have no effect on any status bit or on irqOut.
- R10: The address is {kind[1:0], word}. Kind 0 is the mask, kind 1 is status, kind 2 is clear, and kind 3 reads 0 and ignores writes. Word 0 holds sources 31..0 and word 1 holds sources 63..32. Mask words read back their last written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Interrupt source levels, active high |
| wrEn | input | 1 | Register write enable |
| addr | input | 2+WIDX_W | Register address {kind, word} |
| wrData | input | WORD_W | Register write data |
| rdData | output | WORD_W | Combinational read data for addr |
| irqOut | output | 1 | Registered combined interrupt request |

## Verification
The hardest case to reach from the ports is a source capture and a clear meeting the same status bit at the same edge, and right after it, a source that is only active during the hold-off cycle. Random traffic seldom lines these up. Directed sequences therefore place a single-cycle source pulse in the clear-pulse cycle, then in the hold-off cycle, and check that status stays low in both cases. A persistent source is then used to count the exact edge on which its status comes back. Seeded random traffic on sources, mask writes and clear writes runs against a bench-side model, so that clears overlapping new captures across both words are covered as well.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Register kinds selected by the top two address bits.
  typedef enum logic [1:0] {
    KIND_MASK   = 2'd0,
    KIND_STATUS = 2'd1,
    KIND_CLEAR  = 2'd2,
    KIND_NONE   = 2'd3
  } regKind_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     maskWr;
    logic     clrWr;
    regKind_e rdKind;
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int unsigned WORDS  = 2,
  parameter int unsigned WIDX_W = 1,
  localparam int unsigned ADDR_W = 2 + WIDX_W
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strobes,
  output logic [WIDX_W-1:0] wordIdx
);

  regKind_e kind;
  logic     wordValid;

  always_comb begin
    kind      = regKind_e'(addr[ADDR_W-1 -: 2]);
    wordIdx   = addr[WIDX_W-1:0];
    wordValid = ({1'b0, wordIdx} < (WIDX_W+1)'(WORDS));
  end

  always_comb begin
    strobes.maskWr = wrEn && wordValid && (kind == KIND_MASK);
    strobes.clrWr  = wrEn && wordValid && (kind == KIND_CLEAR);
    strobes.rdKind = wordValid ? kind : KIND_NONE;
  end

endmodule

// File: rtl/irq_agg_word.sv
module irq_agg_word #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] srcIn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              maskWr,
  input  logic              clrWr,
  output logic [WORD_W-1:0] maskQ,
  output logic [WORD_W-1:0] statusQ,
  output logic [WORD_W-1:0] clearQ,
  output logic [WORD_W-1:0] holdQ,
  output logic              anyStatus
);

  logic [WORD_W-1:0] captureVec;
  logic [WORD_W-1:0] statusNext;

  always_comb begin
    // Enabled, not held off; clear dominates capture.
    captureVec = srcIn & ~maskQ & ~holdQ;
    statusNext = (statusQ | captureVec) & ~clearQ;
    anyStatus  = |statusQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '1;
      statusQ <= '0;
      clearQ  <= '0;
      holdQ   <= '0;
    end else begin
      if (maskWr) maskQ <= wrData;
      clearQ  <= clrWr ? wrData : '0;
      holdQ   <= clearQ;
      statusQ <= statusNext;
    end
  end

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned WORDS   = 2,
  parameter int unsigned WIDX_W  = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [WORD_W-1:0]  wrData,
  input  ctrlStrobes_t       strobes,
  input  logic [WIDX_W-1:0]  wordIdx,
  output logic [WORD_W-1:0]  rdData,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] maskAll,
  output logic [NUM_SRC-1:0] statusAll,
  output logic [NUM_SRC-1:0] clearAll,
  output logic [NUM_SRC-1:0] holdAll
);

  logic [WORD_W-1:0] maskW   [WORDS];
  logic [WORD_W-1:0] statusW [WORDS];
  logic [WORDS-1:0]  anyVec;
  logic              irqQ;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic selHit;
    assign selHit = (wordIdx == WIDX_W'(w));

    irq_agg_word #(.WORD_W(WORD_W)) u_word (
      .clk       (clk),
      .rstN      (rstN),
      .srcIn     (srcIn[w*WORD_W +: WORD_W]),
      .wrData    (wrData),
      .maskWr    (strobes.maskWr && selHit),
      .clrWr     (strobes.clrWr && selHit),
      .maskQ     (maskAll[w*WORD_W +: WORD_W]),
      .statusQ   (statusAll[w*WORD_W +: WORD_W]),
      .clearQ    (clearAll[w*WORD_W +: WORD_W]),
      .holdQ     (holdAll[w*WORD_W +: WORD_W]),
      .anyStatus (anyVec[w])
    );

    assign maskW[w]   = maskAll[w*WORD_W +: WORD_W];
    assign statusW[w] = statusAll[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |anyVec;
  end

  assign irqOut = irqQ;

  // Clear words always read as zero.
  always_comb begin
    unique case (strobes.rdKind)
      KIND_MASK:   rdData = maskW[wordIdx];
      KIND_STATUS: rdData = statusW[wordIdx];
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter  int unsigned NUM_SRC = 64,
  parameter  int unsigned WORD_W  = 32,
  localparam int unsigned WORDS   = NUM_SRC / WORD_W,
  localparam int unsigned WIDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int unsigned ADDR_W  = 2 + WIDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  rdData,
  output logic               irqOut
);

  ctrlStrobes_t       strobes;
  logic [WIDX_W-1:0]  wordIdx;
  logic [NUM_SRC-1:0] maskAll;
  logic [NUM_SRC-1:0] statusAll;
  logic [NUM_SRC-1:0] clearAll;
  logic [NUM_SRC-1:0] holdAll;

  irq_agg_ctrl #(.WORDS(WORDS), .WIDX_W(WIDX_W)) u_ctrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .strobes (strobes),
    .wordIdx (wordIdx)
  );

  irq_agg_datapath #(
    .NUM_SRC(NUM_SRC), .WORD_W(WORD_W), .WORDS(WORDS), .WIDX_W(WIDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .wrData    (wrData),
    .strobes   (strobes),
    .wordIdx   (wordIdx),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .maskAll   (maskAll),
    .statusAll (statusAll),
    .clearAll  (clearAll),
    .holdAll   (holdAll)
  );

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int unsigned NUM_SRC = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] maskAll,
  input logic [NUM_SRC-1:0] statusAll,
  input logic [NUM_SRC-1:0] clearAll,
  input logic [NUM_SRC-1:0] holdAll
);

  p_masked_no_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((statusAll & ~$past(statusAll) & $past(maskAll)) == '0));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (($past(srcIn) & ~$past(maskAll) & ~$past(holdAll)
               & ~$past(clearAll) & ~statusAll) == '0));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (($past(statusAll) & ~statusAll & ~$past(clearAll)) == '0));

  p_irq_or_r4: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (irqOut == (|$past(statusAll))));

  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((statusAll & $past(clearAll)) == '0));

  p_hold_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (holdAll == $past(clearAll)));

  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((statusAll & ~$past(statusAll) & $past(holdAll)) == '0));

endmodule

bind irq_aggregator irq_agg_checker #(.NUM_SRC(NUM_SRC)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .srcIn     (srcIn),
  .irqOut    (irqOut),
  .maskAll   (maskAll),
  .statusAll (statusAll),
  .clearAll  (clearAll),
  .holdAll   (holdAll)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;

  localparam int unsigned NSRC = 64;
  localparam logic [2:0] A_MASK_LO = 3'd0, A_MASK_HI = 3'd1,
                         A_STAT_LO = 3'd2, A_STAT_HI = 3'd3,
                         A_CLR_LO  = 3'd4, A_CLR_HI  = 3'd5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] srcIn = '0;
  logic            wrEn = 1'b0;
  logic [2:0]      addr = '0;
  logic [31:0]     wrData = '0;
  logic [31:0]     rdData;
  logic            irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Bench-side model, built from the requirements.
  logic [NSRC-1:0] mMask, mStatus, mClear, mHold;
  logic            mIrq;

  always #5 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [31:0] expRead(input logic [2:0] a);
    logic [NSRC-1:0] v;
    case (a[2:1])
      2'd0:    v = mMask;
      2'd1:    v = mStatus;
      default: v = '0;
    endcase
    return a[0] ? v[63:32] : v[31:0];
  endfunction

  task automatic modelReset();
    mMask = '1; mStatus = '0; mClear = '0; mHold = '0; mIrq = 1'b0;
  endtask

  task automatic modelEdge();
    logic [NSRC-1:0] nStatus, nClear;
    nStatus = (mStatus | (srcIn & ~mMask & ~mHold)) & ~mClear;
    nClear  = '0;
    if (wrEn && addr[2:1] == 2'd2) begin
      if (addr[0]) nClear[63:32] = wrData; else nClear[31:0] = wrData;
    end
    if (wrEn && addr[2:1] == 2'd0) begin
      if (addr[0]) mMask[63:32] = wrData; else mMask[31:0] = wrData;
    end
    mIrq    = |mStatus;
    mHold   = mClear;
    mClear  = nClear;
    mStatus = nStatus;
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic checkRead(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    checkEq(req, rdData, exp);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkEq("R1 irq", {31'b0, irqOut}, 32'h0);
    checkRead("R1 mask lo", A_MASK_LO, 32'hFFFF_FFFF);
    checkRead("R1 mask hi", A_MASK_HI, 32'hFFFF_FFFF);
    checkRead("R1 status lo", A_STAT_LO, 32'h0);
    checkRead("R1 clear hi", A_CLR_HI, 32'h0);

    // R2 all sources active, all masked
    srcIn = '1;
    repeat (3) step();
    checkRead("R2 status lo", A_STAT_LO, 32'h0);
    checkRead("R2 status hi", A_STAT_HI, 32'h0);
    checkEq("R2 irq", {31'b0, irqOut}, 32'h0);
    srcIn = '0;

    // R10 word select and mask readback
    writeReg(A_MASK_LO, 32'hFFFF_FFDE);   // enable bits 0 and 5
    writeReg(A_MASK_HI, 32'hFFFF_FFFD);   // enable bit 33
    checkRead("R10 mask lo", A_MASK_LO, 32'hFFFF_FFDE);
    checkRead("R10 mask hi", A_MASK_HI, 32'hFFFF_FFFD);
    checkRead("R10 kind3", 3'd6, 32'h0);

    // R3 single-cycle pulse on bit 0, sticky
    srcIn[0] = 1'b1;
    step();
    srcIn[0] = 1'b0;
    checkRead("R3 capture", A_STAT_LO, 32'h1);
    checkEq("R4 irq lags", {31'b0, irqOut}, 32'h0);
    step();
    checkRead("R3 sticky", A_STAT_LO, 32'h1);
    checkEq("R4 irq set", {31'b0, irqOut}, 32'h1);

    // R9 status write ignored
    writeReg(A_STAT_LO, 32'h0);
    writeReg(A_STAT_HI, 32'hFFFF_FFFF);
    checkRead("R9 status lo", A_STAT_LO, 32'h1);
    checkRead("R9 status hi", A_STAT_HI, 32'h0);
    checkEq("R9 irq", {31'b0, irqOut}, 32'h1);

    // R5 clear bit 0, R6 clear reads zero
    writeReg(A_CLR_LO, 32'h1);
    checkRead("R6 clear reads 0", A_CLR_LO, 32'h0);
    checkRead("R5 not yet", A_STAT_LO, 32'h1);
    step();
    checkRead("R5 cleared", A_STAT_LO, 32'h0);
    checkEq("R4 irq still", {31'b0, irqOut}, 32'h1);
    step();
    checkEq("R4 irq drop", {31'b0, irqOut}, 32'h0);

    // R7 persistent source on bit 33 comes back on third edge
    srcIn[33] = 1'b1;
    step();
    checkRead("R3 hi capture", A_STAT_HI, 32'h2);
    writeReg(A_CLR_HI, 32'h2);
    step();
    checkRead("R7 edge1", A_STAT_HI, 32'h0);
    step();
    checkRead("R7 edge2", A_STAT_HI, 32'h0);
    step();
    checkRead("R7 edge3", A_STAT_HI, 32'h2);
    srcIn[33] = 1'b0;
    writeReg(A_CLR_HI, 32'h2);
    step();
    checkRead("R6 self clear", A_STAT_HI, 32'h0);

    // R8 capture and clear at the same edge
    writeReg(A_CLR_LO, 32'h20);
    srcIn[5] = 1'b1;
    step();
    srcIn[5] = 1'b0;
    step();
    checkRead("R8 clear wins", A_STAT_LO, 32'h0);

    // R7 pulse only during hold-off cycle
    writeReg(A_CLR_LO, 32'h20);
    step();
    srcIn[5] = 1'b1;
    step();
    srcIn[5] = 1'b0;
    step();
    checkRead("R7 held off", A_STAT_LO, 32'h0);

    // R5 unwritten bits keep value
    srcIn[0] = 1'b1; srcIn[5] = 1'b1;
    step();
    srcIn = '0;
    writeReg(A_CLR_LO, 32'h1);
    step();
    checkRead("R5 partial", A_STAT_LO, 32'h20);

    // Random traffic against the model (R2..R10)
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] ra;
      srcIn = {$urandom, $urandom} & {$urandom, $urandom};
      wrEn  = ($urandom % 4) == 0;
      addr  = 3'($urandom % 8);
      wrData = (addr[2:1] == 2'd2) ? ($urandom & $urandom) : $urandom;
      step();
      wrEn = 1'b0;
      checkEq("R4 random irq", {31'b0, irqOut}, {31'b0, mIrq});
      ra = 3'($urandom % 8);
      checkRead("R3 random read", ra, expRead(ra));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule